// File: doc/BRIEF.md
# Restartable Load-Multiple Sequencer

This block sequences a load-multiple operation on a processor with address translation. A single command names a first and a last destination register, a base value and an offset. The block then fills that run of registers with consecutive words from memory, starting at base plus offset. Registers are written in ascending order, and the register number wraps from the top of the file back to zero.

Before it reads anything, the block works out where the final word lies and asks the translation unit whether that address is valid. If the answer is a fault, the block raises a trap and touches no register, so the instruction can be retried from scratch. This matters when the base register is one of the destinations. A fault found partway through the load would have already destroyed the base, and a restart would compute the wrong address. The start address is latched when the command is accepted, so later changes on the command inputs have no effect on the transfer.

The memory read port has a fixed latency of one cycle. The word for a read issued in cycle c is on `mem_rdata` throughout cycle c+1.

Top module: `ldm_sequencer`

## Requirements
- R1: After reset, `probe_req`, `mem_rd`, `rf_we`, `done` and `trap` are all low.
- R2: After a command is accepted, `probe_req` goes high with `probe_addr` = base + offset + 4*((last − first) mod 16). Both hold steady until a cycle in which `probe_resp` is high.
- R3: A probe answer with `probe_fault` high produces a one-cycle `trap` pulse. It produces no memory read, no register write and no `done`.
- R4: A valid probe leads to exactly ((last − first) mod 16) + 1 register writes. The destinations run first, first+1, …, and wrap from 15 to 0.
- R5: The k-th write (k from 0) carries the word read from address base + offset + 4k. All addresses wrap modulo 2^32.
- R6: No memory read and no register write happens while the probe is still outstanding.
- R7: Base, offset and register numbers are captured when the command is accepted. Changing those inputs afterwards does not alter the transfer.
- R8: `done` is a single-cycle pulse in the cycle after the last register write. It never coincides with `trap`.
- R9: A `start_vld` that arrives while an operation is in progress is ignored.
- R10: Each register write occurs exactly two cycles after the memory read that fetched its word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_vld | input | 1 | Command strobe, accepted only when idle |
| start_first | input | 4 | First destination register |
| start_last | input | 4 | Last destination register |
| start_base | input | 32 | Base register value |
| start_ofs | input | 32 | Address offset |
| probe_req | output | 1 | Translation probe request |
| probe_addr | output | 32 | Address of the final word being probed |
| probe_resp | input | 1 | Probe answer strobe |
| probe_fault | input | 1 | Probe answer is a fault (valid with probe_resp) |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 32 | Read data, one cycle after mem_rd |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| done | output | 1 | Completion pulse |
| trap | output | 1 | Translation fault pulse |

## Verification
The bench sweeps every pair of first and last register numbers. It varies the probe latency and chooses faulting probes with an arithmetic rule. For each pair it checks the probed final address, the number of writes, their order and their data against values it computes itself. A design that probed the first word instead of the last word, or used last − first without the +1 count, would show wrong probe addresses or a missing or extra write. A design that failed to wrap the register index would write register 16's alias in the wrong place on the wrapped pairs. Faulting probes catch any write or `done` leaking out after a trap. Spurious commands during a load and garbage on the base inputs after acceptance catch a design that re-samples its command or restarts mid-transfer.

// File: rtl/ldm_pkg.sv
package ldm_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_PROBE = 2'd1,
    S_LOAD  = 2'd2,
    S_DRAIN = 2'd3
  } ldm_state_e;
endpackage

// File: rtl/ldm_span.sv
module ldm_span #(
  parameter int AW = 32,
  parameter int RN = 4,
  parameter int WORD_BYTES = 4
) (
  input  logic [RN-1:0] first_i,
  input  logic [RN-1:0] last_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] ofs_i,
  output logic [AW-1:0] start_addr_o,
  output logic [AW-1:0] final_addr_o,
  output logic [RN:0]   count_o
);
  localparam int WSH = $clog2(WORD_BYTES);

  logic [RN-1:0] delta;

  always_comb begin
    delta        = last_i - first_i;
    start_addr_o = base_i + ofs_i;
    final_addr_o = start_addr_o + (AW'(delta) << WSH);
    count_o      = {1'b0, delta} + (RN+1)'(1);
  end
endmodule

// File: rtl/ldm_wrstage.sv
module ldm_wrstage #(
  parameter int DW = 32,
  parameter int RN = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_i,
  input  logic [RN-1:0] rd_tag_i,
  input  logic          rd_last_i,
  input  logic [DW-1:0] rdata_i,
  output logic          rf_we_o,
  output logic [RN-1:0] rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o,
  output logic          done_o
);
  logic          pend;
  logic [RN-1:0] pend_tag;
  logic          pend_last;
  logic          wr_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= 1'b0;
      pend_tag   <= '0;
      pend_last  <= 1'b0;
      rf_we_o    <= 1'b0;
      rf_waddr_o <= '0;
      rf_wdata_o <= '0;
      wr_last    <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      pend      <= rd_i;
      pend_tag  <= rd_tag_i;
      pend_last <= rd_i & rd_last_i;
      rf_we_o   <= pend;
      wr_last   <= pend & pend_last;
      if (pend) begin
        rf_waddr_o <= pend_tag;
        rf_wdata_o <= rdata_i;
      end
      done_o <= rf_we_o & wr_last;
    end
  end

  // R10
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> $past(rd_i, 2));

  // R4
  wr_order_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_we_o && $past(rf_we_o)) |-> rf_waddr_o == $past(rf_waddr_o) + RN'(1));
endmodule

// File: rtl/ldm_sequencer.sv
module ldm_sequencer #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int RN = 4,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_vld,
  input  logic [RN-1:0] start_first,
  input  logic [RN-1:0] start_last,
  input  logic [AW-1:0] start_base,
  input  logic [AW-1:0] start_ofs,
  output logic          probe_req,
  output logic [AW-1:0] probe_addr,
  input  logic          probe_resp,
  input  logic          probe_fault,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          rf_we,
  output logic [RN-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          done,
  output logic          trap
);
  import ldm_pkg::*;

  localparam int CW = RN + 1;

  ldm_state_e    st;
  logic [AW-1:0] cur_addr;
  logic [RN-1:0] cur_reg;
  logic [CW-1:0] remain;
  logic [AW-1:0] start_addr_w;
  logic [AW-1:0] final_addr_w;
  logic [CW-1:0] count_w;
  logic [RN-1:0] rd_tag;
  logic          rd_last;
  logic          passed;
  logic          probe_ok;
  logic          issue;

  ldm_span #(.AW(AW), .RN(RN), .WORD_BYTES(WORD_BYTES)) u_span (
    .first_i      (start_first),
    .last_i       (start_last),
    .base_i       (start_base),
    .ofs_i        (start_ofs),
    .start_addr_o (start_addr_w),
    .final_addr_o (final_addr_w),
    .count_o      (count_w)
  );

  assign probe_ok = (st == S_PROBE) && probe_resp && !probe_fault;
  assign issue    = probe_ok || (st == S_LOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cur_addr   <= '0;
      cur_reg    <= '0;
      remain     <= '0;
      probe_req  <= 1'b0;
      probe_addr <= '0;
      mem_rd     <= 1'b0;
      mem_addr   <= '0;
      rd_tag     <= '0;
      rd_last    <= 1'b0;
      trap       <= 1'b0;
      passed     <= 1'b0;
    end else begin
      trap   <= 1'b0;
      mem_rd <= issue;
      if (issue) begin
        mem_addr <= cur_addr;
        rd_tag   <= cur_reg;
        rd_last  <= (remain == CW'(1));
        cur_addr <= cur_addr + AW'(WORD_BYTES);
        cur_reg  <= cur_reg + RN'(1);
        remain   <= remain - CW'(1);
      end
      unique case (st)
        S_IDLE: begin
          passed <= 1'b0;
          if (start_vld) begin
            cur_addr   <= start_addr_w;
            cur_reg    <= start_first;
            remain     <= count_w;
            probe_req  <= 1'b1;
            probe_addr <= final_addr_w;
            st         <= S_PROBE;
          end
        end
        S_PROBE: begin
          if (probe_resp) begin
            probe_req <= 1'b0;
            if (probe_fault) begin
              trap <= 1'b1;
              st   <= S_IDLE;
            end else begin
              passed <= 1'b1;
              st     <= (remain == CW'(1)) ? S_DRAIN : S_LOAD;
            end
          end
        end
        S_LOAD: begin
          if (remain == CW'(1)) st <= S_DRAIN;
        end
        S_DRAIN: begin
          if (done) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  ldm_wrstage #(.DW(DW), .RN(RN)) u_wr (
    .clk        (clk),
    .rst        (rst),
    .rd_i       (mem_rd),
    .rd_tag_i   (rd_tag),
    .rd_last_i  (rd_last),
    .rdata_i    (mem_rdata),
    .rf_we_o    (rf_we),
    .rf_waddr_o (rf_waddr),
    .rf_wdata_o (rf_wdata),
    .done_o     (done)
  );

  // R2
  probe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (probe_req && !probe_resp) |=> (probe_req && $stable(probe_addr)));

  // R6
  no_early_access_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || rf_we) |-> (passed && !probe_req));

  // R3
  trap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    trap |-> (!mem_rd && !rf_we && !done));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_trap_excl_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !trap);
endmodule

// File: tb/sim_ldm_sequencer.sv
`timescale 1ns/1ps
module sim_ldm_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_vld = 1'b0;
  logic [3:0]  start_first = '0;
  logic [3:0]  start_last = '0;
  logic [31:0] start_base = '0;
  logic [31:0] start_ofs = '0;
  logic        probe_req;
  logic [31:0] probe_addr;
  logic        probe_resp = 1'b0;
  logic        probe_fault = 1'b0;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        rf_we;
  logic [3:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic        done;
  logic        trap;

  always #2.5 clk = ~clk;

  ldm_sequencer u0 (
    .clk(clk), .rst(rst), .start_vld(start_vld), .start_first(start_first),
    .start_last(start_last), .start_base(start_base), .start_ofs(start_ofs),
    .probe_req(probe_req), .probe_addr(probe_addr), .probe_resp(probe_resp),
    .probe_fault(probe_fault), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .done(done), .trap(trap)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_5A5A;
  endfunction

  // memory model with one cycle of read latency
  always @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int nwr = 0, nrd = 0, ndone = 0, ntrap = 0, npreq = 0, nearly = 0;
  logic [3:0]  wr_reg [4200];
  logic [31:0] wr_dat [4200];
  int          wr_cyc [4200];
  int          rd_cyc [4200];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rf_we && nwr < 4200) begin
      wr_reg[nwr] <= rf_waddr; wr_dat[nwr] <= rf_wdata; wr_cyc[nwr] <= cyc;
      nwr <= nwr + 1;
    end
    if (mem_rd && nrd < 4200) begin rd_cyc[nrd] <= cyc; nrd <= nrd + 1; end
    if (done) ndone <= ndone + 1;
    if (trap) ntrap <= ntrap + 1;
    if (probe_req) npreq <= npreq + 1;
    if (probe_req && (mem_rd || rf_we)) nearly <= nearly + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input int f, input int l, input int lat, input bit flt,
                        input bit spur, input logic [31:0] base,
                        input logic [31:0] ofs);
    int s_wr, s_rd, s_done, s_trap, s_preq, s_early, span, werr, terr, guard;
    logic [31:0] st_addr, fin, paddr;
    span    = ((l - f) & 15) + 1;
    st_addr = base + ofs;
    fin     = st_addr + 32'(4 * (span - 1));
    s_wr = nwr; s_rd = nrd; s_done = ndone; s_trap = ntrap;
    s_preq = npreq; s_early = nearly;
    start_vld = 1'b1; start_first = 4'(f); start_last = 4'(l);
    start_base = base; start_ofs = ofs;
    @(negedge clk);
    start_vld = 1'b0;
    // R7: command inputs scrambled once accepted
    start_base = ~base; start_ofs = 32'hDEAD_0000; start_first = 4'(l); start_last = 4'(f);
    guard = 0;
    while (!probe_req && guard < 20) begin @(negedge clk); guard++; end
    paddr = probe_addr;
    repeat (lat) @(negedge clk);
    probe_resp = 1'b1; probe_fault = flt;
    @(negedge clk);
    probe_resp = 1'b0; probe_fault = 1'b0;
    if (spur) begin
      // R9: stray command during the transfer
      start_vld = 1'b1; start_first = 4'd0; start_last = 4'd15; start_base = 32'h0;
      @(negedge clk);
      start_vld = 1'b0;
    end
    guard = 0;
    while (ndone == s_done && ntrap == s_trap && guard < 60) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
    #1;
    check(paddr == fin, "R2", "probe address", 64'(paddr), 64'(fin));
    check(npreq - s_preq == lat + 1, "R2", "probe hold cycles",
          64'(npreq - s_preq), 64'(lat + 1));
    check(nearly == s_early, "R6", "access during probe", 64'(nearly - s_early), 64'd0);
    if (flt) begin
      check(ntrap - s_trap == 1 && nwr == s_wr && nrd == s_rd && ndone == s_done,
            "R3", "trap with no side effects",
            64'(ntrap - s_trap) << 32 | 64'(nwr - s_wr), 64'h1_0000_0000);
    end else begin
      werr = 0; terr = 0;
      check(nwr - s_wr == span, spur ? "R4/R9" : "R4", "write count",
            64'(nwr - s_wr), 64'(span));
      for (int k = 0; k < span && (s_wr + k) < nwr; k++) begin
        if (wr_reg[s_wr+k] != 4'((f + k) & 15)) werr++;
        if (wr_dat[s_wr+k] != memf(st_addr + 32'(4 * k))) werr++;
        if (wr_cyc[s_wr+k] != rd_cyc[s_rd+k] + 2) terr++;
      end
      check(werr == 0, spur ? "R5/R7/R9" : "R5/R7", "write order and data",
            64'(werr), 64'd0);
      check(terr == 0, "R10", "write two cycles after read", 64'(terr), 64'd0);
      check(ndone - s_done == 1 && ntrap == s_trap &&
            (cyc >= 0) && done == 1'b0, "R8", "single done, no trap",
            64'(ndone - s_done), 64'd1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(!probe_req && !mem_rd && !rf_we && !done && !trap, "R1", "reset outputs",
          64'({probe_req, mem_rd, rf_we, done, trap}), 64'd0);
    for (int f = 0; f < 16; f++) begin
      for (int l = 0; l < 16; l++) begin
        int  lat;
        bit  flt, spur;
        logic [31:0] base, ofs;
        lat  = (f ^ l) % 4;
        flt  = ((f + 3 * l) % 5) == 0;
        spur = !flt && (f % 2 == 1);
        base = (l % 4 == 3) ? 32'hFFFF_FFE0 : 32'h1000_0000 + 32'(f * 32'h1234);
        ofs  = 32'(l * 32'h40) - 32'd8;
        run_op(f, l, lat, flt, spur, base, ofs);
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule